// File: doc/BRIEF.md
# UART Control and Interrupt Request Unit

This unit holds the control settings of one UART channel and turns status reported by the UART datapath into interrupt requests. The datapath supplies flags for an empty transmit buffer, a reached transmit FIFO threshold, received data waiting, a reached receive FIFO threshold, a receive timeout, and framing and overrun errors. The unit drives three request lines: transmit, receive and error. Each direction has its own request style. It can give a single-cycle pulse on the rising edge of its trigger condition, or a level that follows the condition. The trigger condition for each direction depends on whether FIFO operation is enabled.

The same control word selects the source of the baud tick (peripheral clock or external UART clock) and the loopback test path. In loopback the serial transmit output feeds the receive input, and the pads are isolated. Software loads the divisor for the selected source as floor(f_clk / (16 × baud)) − 1; the divisor counter is outside this unit. The control word is written as one parallel value through a write strobe. It resets to all zeros.

Top module: `uart_ctl_irq`

## Requirements
- R1: After reset the control word is zero. All request lines are low, the peripheral tick is selected, and the pads are connected straight through.
- R2: A control word presented with `ctrl_we_i` high is captured at that clock edge. Bit 0 is loopback, bit 1 is error request enable, bit 2 is timeout enable, bit 3 is receive level mode, bit 4 is transmit level mode, bit 5 is external clock select and bit 6 is FIFO enable. The new settings govern requests registered from the next edge onward.
- R3: The transmit trigger is `tx_buf_empty_i` when FIFO operation is off and `tx_fifo_trig_i` when it is on. The flag that is not selected has no effect.
- R4: In pulse mode a request line is high for exactly one cycle, one clock edge after its trigger rises. A trigger that is already high when pulse mode is selected gives no pulse until it falls and rises again.
- R5: In level mode a request line is high from one edge after its trigger rises until one edge after the trigger falls.
- R6: The receive trigger is `rx_buf_ready_i` when FIFO operation is off and `rx_fifo_trig_i` when it is on. It uses the receive mode bit.
- R7: `rx_timeout_i` raises the receive request, in the receive mode, only when both the timeout enable and FIFO enable bits are set.
- R8: With the error enable set, `frame_err_i` or `overrun_err_i` raises the error request in the receive mode. With it clear, errors never raise it.
- R9: With loopback set, `rx_serial_o` follows `tx_serial_i`, `txd_pad_o` is held high and `rxd_pad_i` is ignored. With loopback clear, `txd_pad_o` follows `tx_serial_i` and `rx_serial_o` follows `rxd_pad_i`.
- R10: The clock select bit makes `baud_tick_o` follow `ext_tick_i` when set and `pclk_tick_i` when clear. `baud_src_ext_o` shows the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 7 | Control word |
| tx_buf_empty_i | input | 1 | Transmit holding buffer empty |
| tx_fifo_trig_i | input | 1 | Transmit FIFO at trigger level |
| rx_buf_ready_i | input | 1 | Received data in holding buffer |
| rx_fifo_trig_i | input | 1 | Receive FIFO at trigger level |
| rx_timeout_i | input | 1 | Receive timeout flag |
| frame_err_i | input | 1 | Framing error flag |
| overrun_err_i | input | 1 | Overrun error flag |
| tx_serial_i | input | 1 | Serial data from transmit shifter |
| rxd_pad_i | input | 1 | Receive pad |
| pclk_tick_i | input | 1 | Baud tick from peripheral clock |
| ext_tick_i | input | 1 | Baud tick from external clock |
| txd_pad_o | output | 1 | Transmit pad |
| rx_serial_o | output | 1 | Serial data to receive shifter |
| baud_tick_o | output | 1 | Selected baud tick |
| baud_src_ext_o | output | 1 | External source selected |
| tx_irq_o | output | 1 | Transmit request |
| rx_irq_o | output | 1 | Receive request |
| err_irq_o | output | 1 | Receive error request |

## Verification
Request lines are registered. A trigger change driven on a falling edge appears one rising edge later, and a control write needs one edge to land and takes effect on requests at the edge after that. The loopback path and the baud source select are combinational from the control register, so they are valid right after the write edge. The bench drives every input on the falling edge and samples at the following falling edge. Each pulse is checked both in its cycle and in the cycle after it, so a stuck or doubled pulse is caught.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

  typedef struct packed {
    logic fifo_en;    // [6]
    logic clk_ext;    // [5]
    logic tx_level;   // [4]
    logic rx_level;   // [3]
    logic tmo_en;     // [2]
    logic err_en;     // [1]
    logic loopback;   // [0]
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    SRC_TX  = 2'd0,
    SRC_RX  = 2'd1,
    SRC_TMO = 2'd2,
    SRC_ERR = 2'd3
  } irq_src_e;

  localparam int unsigned NUM_SRC = 4;

endpackage

// File: rtl/uart_ctl_reg.sv
module uart_ctl_reg
  import uart_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= ctrl_t'(wdata_i);
  end

  assign ctrl_o = ctrl_q;

  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));

endmodule

// File: rtl/uart_irq_req.sv
module uart_irq_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic cond_i,
  output logic irq_o
);

  logic cond_q, irq_q;

  // history tracks the condition in both modes so a mode change never fakes an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cond_q <= cond_i;
      irq_q  <= level_i ? cond_i : (cond_i & ~cond_q);
    end
  end

  assign irq_o = irq_q;

  // R4
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !level_i |=> !irq_o);

  // R5
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i && cond_i |=> irq_o);

  // R4, R5
  no_cond_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> !irq_o);

endmodule

// File: rtl/uart_line_route.sv
module uart_line_route (
  input  logic loopback_i,
  input  logic clk_ext_i,
  input  logic tx_serial_i,
  input  logic rxd_pad_i,
  input  logic pclk_tick_i,
  input  logic ext_tick_i,
  output logic txd_pad_o,
  output logic rx_serial_o,
  output logic baud_tick_o,
  output logic baud_src_ext_o
);

  localparam logic LINE_IDLE = 1'b1;

  always_comb begin
    if (loopback_i) begin
      txd_pad_o   = LINE_IDLE;
      rx_serial_o = tx_serial_i;
    end else begin
      txd_pad_o   = tx_serial_i;
      rx_serial_o = rxd_pad_i;
    end
  end

  assign baud_tick_o    = clk_ext_i ? ext_tick_i : pclk_tick_i;
  assign baud_src_ext_o = clk_ext_i;

endmodule

// File: rtl/uart_ctl_irq.sv
module uart_ctl_irq
  import uart_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              tx_buf_empty_i,
  input  logic              tx_fifo_trig_i,
  input  logic              rx_buf_ready_i,
  input  logic              rx_fifo_trig_i,
  input  logic              rx_timeout_i,
  input  logic              frame_err_i,
  input  logic              overrun_err_i,
  input  logic              tx_serial_i,
  input  logic              rxd_pad_i,
  input  logic              pclk_tick_i,
  input  logic              ext_tick_i,
  output logic              txd_pad_o,
  output logic              rx_serial_o,
  output logic              baud_tick_o,
  output logic              baud_src_ext_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);

  ctrl_t              ctrl;
  logic [NUM_SRC-1:0] src_cond;
  logic [NUM_SRC-1:0] src_lvl;
  logic [NUM_SRC-1:0] src_irq;

  uart_ctl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl)
  );

  always_comb begin
    src_cond[SRC_TX]  = ctrl.fifo_en ? tx_fifo_trig_i : tx_buf_empty_i;
    src_cond[SRC_RX]  = ctrl.fifo_en ? rx_fifo_trig_i : rx_buf_ready_i;
    src_cond[SRC_TMO] = rx_timeout_i & ctrl.tmo_en & ctrl.fifo_en;
    src_cond[SRC_ERR] = (frame_err_i | overrun_err_i) & ctrl.err_en;
    src_lvl           = {NUM_SRC{ctrl.rx_level}};
    src_lvl[SRC_TX]   = ctrl.tx_level;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    uart_irq_req u_req (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (src_lvl[g]),
      .cond_i  (src_cond[g]),
      .irq_o   (src_irq[g])
    );
  end

  assign tx_irq_o  = src_irq[SRC_TX];
  assign rx_irq_o  = src_irq[SRC_RX] | src_irq[SRC_TMO];
  assign err_irq_o = src_irq[SRC_ERR];

  uart_line_route u_route (
    .loopback_i     (ctrl.loopback),
    .clk_ext_i      (ctrl.clk_ext),
    .tx_serial_i    (tx_serial_i),
    .rxd_pad_i      (rxd_pad_i),
    .pclk_tick_i    (pclk_tick_i),
    .ext_tick_i     (ext_tick_i),
    .txd_pad_o      (txd_pad_o),
    .rx_serial_o    (rx_serial_o),
    .baud_tick_o    (baud_tick_o),
    .baud_src_ext_o (baud_src_ext_o)
  );

  // R8
  err_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.err_en |=> !err_irq_o);

  // R7
  tmo_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.fifo_en && !rx_buf_ready_i |=> !rx_irq_o);

  // R9
  loop_pad_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.loopback |-> txd_pad_o);

  // R3
  tx_fifo_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.fifo_en && !tx_fifo_trig_i |=> !tx_irq_o);

endmodule

// File: tb/uart_ctl_irq_tb.sv
module uart_ctl_irq_tb;
  import uart_ctl_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0;
  logic [CTRL_W-1:0] ctrl_wdata = '0;
  logic tx_empty = 0, tx_trig = 0, rx_ready = 0, rx_trig = 0, rx_tmo = 0;
  logic frame_err = 0, overrun = 0, tx_ser = 1, rxd_pad = 1, pclk_tick = 0, ext_tick = 0;
  logic txd_pad, rx_ser, baud_tick, src_ext, tx_irq, rx_irq, err_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  // control bit values
  localparam logic [6:0] C_LOOP = 7'h01, C_ERR = 7'h02, C_TMO = 7'h04, C_RXL = 7'h08,
                         C_TXL = 7'h10, C_EXT = 7'h20, C_FIFO = 7'h40;

  always #2.5 clk = ~clk;

  uart_ctl_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .tx_buf_empty_i(tx_empty), .tx_fifo_trig_i(tx_trig), .rx_buf_ready_i(rx_ready),
    .rx_fifo_trig_i(rx_trig), .rx_timeout_i(rx_tmo), .frame_err_i(frame_err),
    .overrun_err_i(overrun), .tx_serial_i(tx_ser), .rxd_pad_i(rxd_pad),
    .pclk_tick_i(pclk_tick), .ext_tick_i(ext_tick), .txd_pad_o(txd_pad),
    .rx_serial_o(rx_ser), .baud_tick_o(baud_tick), .baud_src_ext_o(src_ext),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [6:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    step();
    ctrl_we = 1'b0;
  endtask

  task automatic settle(input logic [6:0] v);
    tx_empty = 0; tx_trig = 0; rx_ready = 0; rx_trig = 0; rx_tmo = 0;
    frame_err = 0; overrun = 0;
    write_ctrl(v);
    step(); step();
  endtask

  task automatic t_reset();
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 err_irq", err_irq, 0);
    chk("R1 src_ext", src_ext, 0);
    tx_ser = 0; rxd_pad = 0; #1;
    chk("R1 txd_pad", txd_pad, 0);
    chk("R1 rx_ser", rx_ser, 0);
    tx_ser = 1; rxd_pad = 1;
  endtask

  task automatic t_tx_pulse();
    settle(0);
    tx_empty = 1; step();
    chk("R4 tx pulse", tx_irq, 1);
    step();
    chk("R4 tx pulse ends", tx_irq, 0);
    step();
    chk("R4 tx stays low", tx_irq, 0);
  endtask

  task automatic t_tx_level();
    settle(C_TXL);
    tx_empty = 1; step();
    chk("R5 tx level on", tx_irq, 1);
    step(); step();
    chk("R5 tx level held", tx_irq, 1);
    tx_empty = 0; step();
    chk("R5 tx level off", tx_irq, 0);
  endtask

  task automatic t_mode_switch();
    settle(C_TXL);
    tx_empty = 1; step(); step();
    write_ctrl(0);            // R2: captured here, governs next edge
    chk("R2 old mode at write edge", tx_irq, 1);
    step();
    chk("R4 no pulse on held trigger", tx_irq, 0);
    step();
    chk("R4 still no pulse", tx_irq, 0);
    tx_empty = 0; step();
    tx_empty = 1; step();
    chk("R4 pulse after re-rise", tx_irq, 1);
  endtask

  task automatic t_tx_fifo();
    settle(C_FIFO);
    tx_empty = 1; step();
    chk("R3 buffer flag ignored in FIFO mode", tx_irq, 0);
    tx_trig = 1; step();
    chk("R3 FIFO trigger pulse", tx_irq, 1);
    step();
    chk("R3 FIFO trigger pulse ends", tx_irq, 0);
    settle(0);
    tx_trig = 1; step();
    chk("R3 FIFO flag ignored in buffer mode", tx_irq, 0);
  endtask

  task automatic t_rx();
    settle(0);
    rx_ready = 1; step();
    chk("R6 rx buffer pulse", rx_irq, 1);
    step();
    chk("R6 rx pulse ends", rx_irq, 0);
    settle(C_FIFO | C_RXL);
    rx_ready = 1; step();
    chk("R6 rx buffer ignored in FIFO mode", rx_irq, 0);
    rx_trig = 1; step(); step();
    chk("R6 rx FIFO level held", rx_irq, 1);
    rx_trig = 0; step();
    chk("R6 rx FIFO level off", rx_irq, 0);
  endtask

  task automatic t_timeout();
    settle(C_FIFO | C_TMO);
    rx_tmo = 1; step();
    chk("R7 timeout raises rx", rx_irq, 1);
    step();
    chk("R7 timeout pulse ends", rx_irq, 0);
    settle(C_TMO);
    rx_tmo = 1; step();
    chk("R7 timeout needs FIFO", rx_irq, 0);
    settle(C_FIFO);
    rx_tmo = 1; step();
    chk("R7 timeout needs enable", rx_irq, 0);
  endtask

  task automatic t_error();
    settle(0);
    frame_err = 1; overrun = 1; step();
    chk("R8 error masked", err_irq, 0);
    step();
    chk("R8 error masked later", err_irq, 0);
    settle(C_ERR);
    frame_err = 1; step();
    chk("R8 frame error pulse", err_irq, 1);
    step();
    chk("R8 frame pulse ends", err_irq, 0);
    frame_err = 0; step();
    overrun = 1; step();
    chk("R8 overrun pulse", err_irq, 1);
    settle(C_ERR | C_RXL);
    overrun = 1; step(); step();
    chk("R8 error level held", err_irq, 1);
  endtask

  task automatic t_loop();
    settle(C_LOOP);
    tx_ser = 0; rxd_pad = 1; #1;
    chk("R9 loop rx follows tx 0", rx_ser, 0);
    chk("R9 loop pad idle", txd_pad, 1);
    tx_ser = 1; rxd_pad = 0; #1;
    chk("R9 loop rx follows tx 1", rx_ser, 1);
    chk("R9 pad rx ignored", rx_ser, 1);
    settle(0);
    tx_ser = 0; rxd_pad = 0; #1;
    chk("R9 normal txd", txd_pad, 0);
    chk("R9 normal rx", rx_ser, 0);
    tx_ser = 1; rxd_pad = 1;
  endtask

  task automatic t_clk();
    settle(0);
    pclk_tick = 1; ext_tick = 0; #1;
    chk("R10 pclk tick", baud_tick, 1);
    chk("R10 pclk select", src_ext, 0);
    write_ctrl(C_EXT);
    chk("R10 ext select", src_ext, 1);
    chk("R10 ext tick low", baud_tick, 0);
    ext_tick = 1; pclk_tick = 0; #1;
    chk("R10 ext tick", baud_tick, 1);
    ext_tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_tx_pulse();
    t_tx_level();
    t_mode_switch();
    t_tx_fifo();
    t_rx();
    t_timeout();
    t_error();
    t_loop();
    t_clk();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule